// File: doc/BRIEF.md
# Multi-Block Program Page Buffers

This block gathers the data to be programmed into up to eight flash array blocks in one programming session. Each array block owns a 64-byte page buffer. Every buffer is filled by byte writes whose address carries a page offset, a block number and a byte index. The page offset is common to all blocks: the first accepted write of a session fixes it. Any later write that names a different offset is dropped, and a sticky flag reports it.

Buffer bits use logic 1 for "leave unprogrammed" and logic 0 for "program". While the session enable is low, every buffer byte is forced to all ones and the captured offset is forgotten. A margin-read strobe brings in one result bit for every buffer bit in a single cycle. Each result bit that reports an array bit as already programmed returns the matching buffer bit to 1, so that bit is not pulsed again.

An 8-bit block mask does not gate the buffer writes. It only decides which blocks receive the per-block high-voltage enable while the program strobe is active. A byte read port exposes any buffer byte, together with the captured offset and the status flags.

Top module: `prog_page_bufs`

## Requirements
- R1: After a synchronous reset every buffer byte reads 0xFF, `off_vld` is 0 and `off_err` is 0.
- R2: With `ses_en` high, the first write after `off_vld` is 0 captures its page offset. From the next cycle `off_vld` is 1 and `page_off` holds that offset. `page_off` stays unchanged for the rest of the session.
- R3: A write whose offset matches the captured one, or a first write, stores `wr_data` into the addressed byte of the addressed block. The byte is visible on `rd_data` from the next cycle, and no other byte changes.
- R4: A write in a session whose offset differs from the captured one changes no buffer byte. It sets `off_err`, which stays 1 until the session ends.
- R5: Buffer writes are stored whatever the value of `blk_mask`.
- R6: `hv_en[m]` equals `blk_mask[m]` AND `pgm_stb`, in the same cycle.
- R7: In a cycle where `ses_en` is 0, all buffer bytes become 0xFF at the next edge and `off_vld` and `off_err` become 0. Writes and margin strobes in that cycle have no effect.
- R8: With `mrg_stb` high, every buffer bit whose `mrg_prog` bit is 1 becomes 1, and all other bits keep their value. Buffer bit b of byte i in block m maps to `mrg_prog[(m*64+i)*8+b]`.
- R9: When an accepted write and a margin strobe hit the same byte in the same cycle, the stored byte is `wr_data` OR the margin bits of that byte.
- R10: Address fields are fixed: `wr_addr[5:0]` is the byte index, `wr_addr[8:6]` is the block number and `wr_addr[15:9]` is the page offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ses_en | input | 1 | Session enable; low erases buffers and the offset |
| wr_en | input | 1 | Buffer byte write strobe |
| wr_addr | input | 16 | Write address {offset, block, byte} |
| wr_data | input | 8 | Write byte (0 = program) |
| blk_mask | input | 8 | Per-block program select |
| pgm_stb | input | 1 | Program strobe |
| hv_en | output | 8 | Per-block high-voltage enable |
| mrg_stb | input | 1 | Margin-read result valid |
| mrg_prog | input | 4096 | Margin result, 1 = array bit already programmed |
| rd_blk | input | 3 | Read port block number |
| rd_idx | input | 6 | Read port byte index |
| rd_data | output | 8 | Addressed buffer byte |
| page_off | output | 7 | Captured page offset |
| off_vld | output | 1 | Page offset has been captured |
| off_err | output | 1 | A write with a different offset was dropped |

## Verification
A buffer write and a margin-read update can hit the same byte on the same clock edge. The bench provokes this by raising `mrg_stb` in the cycle of an accepted write to a byte whose margin bits are partly set. It judges the stored byte against a reference that applies the write first and then ORs in the margin bits. A second collision is a write arriving in a cycle where `ses_en` is low. The reference expects the erase to win, and a full sweep of all 512 bytes confirms it.

// File: rtl/ppb_pkg.sv
package ppb_pkg;

    localparam int unsigned PPB_NBLK       = 8;
    localparam int unsigned PPB_PAGE_BYTES = 64;
    localparam int unsigned PPB_OFF_W      = 7;

    localparam logic [7:0] PPB_ERASED = 8'hFF;

    typedef enum logic [1:0] {
        OFF_IDLE  = 2'd0,
        OFF_FIRST = 2'd1,
        OFF_MATCH = 2'd2,
        OFF_CLASH = 2'd3
    } off_cls_e;

    function automatic logic [7:0] merge_byte(input logic [7:0] data,
                                              input logic [7:0] done_bits);
        return data | done_bits;
    endfunction

    function automatic logic off_accepted(input off_cls_e cls);
        return (cls == OFF_FIRST) || (cls == OFF_MATCH);
    endfunction

endpackage

// File: rtl/ppb_off_latch.sv
module ppb_off_latch
    import ppb_pkg::*;
#(
    parameter int unsigned OFF_W = PPB_OFF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ses_en,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_off,
    output logic             accept,
    output logic [OFF_W-1:0] off_q,
    output logic             off_vld,
    output logic             off_err
);

    off_cls_e cls;

    always_comb begin
        cls = OFF_IDLE;
        if (ses_en && wr_en) begin
            if (!off_vld)
                cls = OFF_FIRST;
            else if (wr_off == off_q)
                cls = OFF_MATCH;
            else
                cls = OFF_CLASH;
        end
    end

    assign accept = off_accepted(cls);

    always_ff @(posedge clk) begin
        if (rst || !ses_en) begin
            off_q   <= '0;
            off_vld <= 1'b0;
            off_err <= 1'b0;
        end else begin
            case (cls)
                OFF_FIRST: begin
                    off_q   <= wr_off;
                    off_vld <= 1'b1;
                end
                OFF_CLASH: off_err <= 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ppb_page_buf.sv
module ppb_page_buf
    import ppb_pkg::*;
#(
    parameter int unsigned PAGE_BYTES = PPB_PAGE_BYTES,
    localparam int unsigned BYTE_W    = $clog2(PAGE_BYTES),
    localparam int unsigned PAGE_BITS = PAGE_BYTES * 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ses_en,
    input  logic                 wr_hit,
    input  logic [BYTE_W-1:0]    wr_idx,
    input  logic [7:0]           wr_data,
    input  logic                 mrg_stb,
    input  logic [PAGE_BITS-1:0] mrg_vec,
    output logic [PAGE_BITS-1:0] page_q
);

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
        logic [7:0] q;
        logic [7:0] nxt;

        always_comb begin
            nxt = q;
            if (wr_hit && (wr_idx == BYTE_W'(i)))
                nxt = wr_data;
            if (mrg_stb)
                nxt = merge_byte(nxt, mrg_vec[i*8 +: 8]);
        end

        always_ff @(posedge clk) begin
            if (rst || !ses_en)
                q <= PPB_ERASED;
            else
                q <= nxt;
        end

        assign page_q[i*8 +: 8] = q;
    end

endmodule

// File: rtl/ppb_hv_gate.sv
module ppb_hv_gate
    import ppb_pkg::*;
#(
    parameter int unsigned NBLK = PPB_NBLK
) (
    input  logic [NBLK-1:0] blk_mask,
    input  logic            pgm_stb,
    output logic [NBLK-1:0] hv_en
);

    for (genvar m = 0; m < NBLK; m++) begin : g_blk
        assign hv_en[m] = blk_mask[m] & pgm_stb;
    end

endmodule

// File: rtl/prog_page_bufs.sv
module prog_page_bufs
    import ppb_pkg::*;
#(
    parameter int unsigned NBLK       = PPB_NBLK,
    parameter int unsigned PAGE_BYTES = PPB_PAGE_BYTES,
    parameter int unsigned OFF_W      = PPB_OFF_W,
    localparam int unsigned BLK_W     = $clog2(NBLK),
    localparam int unsigned BYTE_W    = $clog2(PAGE_BYTES),
    localparam int unsigned ADDR_W    = OFF_W + BLK_W + BYTE_W,
    localparam int unsigned PAGE_BITS = PAGE_BYTES * 8,
    localparam int unsigned ALL_BITS  = NBLK * PAGE_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ses_en,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [7:0]          wr_data,
    input  logic [NBLK-1:0]     blk_mask,
    input  logic                pgm_stb,
    output logic [NBLK-1:0]     hv_en,
    input  logic                mrg_stb,
    input  logic [ALL_BITS-1:0] mrg_prog,
    input  logic [BLK_W-1:0]    rd_blk,
    input  logic [BYTE_W-1:0]   rd_idx,
    output logic [7:0]          rd_data,
    output logic [OFF_W-1:0]    page_off,
    output logic                off_vld,
    output logic                off_err
);

    typedef struct packed {
        logic [OFF_W-1:0]  off;
        logic [BLK_W-1:0]  blk;
        logic [BYTE_W-1:0] idx;
    } wr_addr_t;

    wr_addr_t            wa;
    logic                accept;
    logic [ALL_BITS-1:0] all_q;

    assign wa = wr_addr_t'(wr_addr);

    ppb_off_latch #(.OFF_W(OFF_W)) u_off (
        .clk     (clk),
        .rst     (rst),
        .ses_en  (ses_en),
        .wr_en   (wr_en),
        .wr_off  (wa.off),
        .accept  (accept),
        .off_q   (page_off),
        .off_vld (off_vld),
        .off_err (off_err)
    );

    for (genvar g = 0; g < NBLK; g++) begin : g_buf
        logic hit;
        assign hit = accept && (wa.blk == BLK_W'(g));

        ppb_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
            .clk     (clk),
            .rst     (rst),
            .ses_en  (ses_en),
            .wr_hit  (hit),
            .wr_idx  (wa.idx),
            .wr_data (wr_data),
            .mrg_stb (mrg_stb),
            .mrg_vec (mrg_prog[g*PAGE_BITS +: PAGE_BITS]),
            .page_q  (all_q[g*PAGE_BITS +: PAGE_BITS])
        );
    end

    ppb_hv_gate #(.NBLK(NBLK)) u_hv (
        .blk_mask (blk_mask),
        .pgm_stb  (pgm_stb),
        .hv_en    (hv_en)
    );

    assign rd_data = all_q[(int'(rd_blk) * PAGE_BYTES + int'(rd_idx)) * 8 +: 8];

endmodule

// File: rtl/ppb_chk.sv
module ppb_chk #(
    parameter int unsigned NBLK  = 8,
    parameter int unsigned OFF_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             ses_en,
    input logic             wr_en,
    input logic [NBLK-1:0]  blk_mask,
    input logic             pgm_stb,
    input logic [NBLK-1:0]  hv_en,
    input logic [7:0]       rd_data,
    input logic [OFF_W-1:0] page_off,
    input logic             off_vld,
    input logic             off_err
);

    // R6
    hv_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !pgm_stb |-> (hv_en == '0));

    // R6
    hv_masked_chk: assert property (@(posedge clk) disable iff (rst)
        ((hv_en & ~blk_mask) == '0));

    // R2
    off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (off_vld && ses_en) |=> $stable(page_off));

    // R2
    off_capture_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(off_vld) |-> ($past(wr_en) && $past(ses_en)));

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (off_err && ses_en) |=> off_err);

    // R7
    ses_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !ses_en |=> (!off_vld && !off_err && (rd_data == 8'hFF)));

endmodule

bind prog_page_bufs ppb_chk #(.NBLK(NBLK), .OFF_W(OFF_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ses_en   (ses_en),
    .wr_en    (wr_en),
    .blk_mask (blk_mask),
    .pgm_stb  (pgm_stb),
    .hv_en    (hv_en),
    .rd_data  (rd_data),
    .page_off (page_off),
    .off_vld  (off_vld),
    .off_err  (off_err)
);

// File: tb/tb_prog_page_bufs.sv
module tb_prog_page_bufs;

    localparam int NB = 8;
    localparam int PB = 64;
    localparam int OW = 7;
    localparam int AW = 16;
    localparam int TB = NB * PB * 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          ses_en;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [NB-1:0] blk_mask;
    logic          pgm_stb;
    logic [NB-1:0] hv_en;
    logic          mrg_stb;
    logic [TB-1:0] mrg_prog;
    logic [2:0]    rd_blk;
    logic [5:0]    rd_idx;
    logic [7:0]    rd_data;
    logic [OW-1:0] page_off;
    logic          off_vld;
    logic          off_err;

    always #5 clk = ~clk;

    prog_page_bufs dut (
        .clk(clk), .rst(rst), .ses_en(ses_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .blk_mask(blk_mask),
        .pgm_stb(pgm_stb), .hv_en(hv_en), .mrg_stb(mrg_stb),
        .mrg_prog(mrg_prog), .rd_blk(rd_blk), .rd_idx(rd_idx),
        .rd_data(rd_data), .page_off(page_off), .off_vld(off_vld),
        .off_err(off_err)
    );

    // reference model
    logic [7:0]    mdl [NB][PB];
    logic [OW-1:0] m_off;
    logic          m_vld;
    logic          m_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        logic [OW-1:0] o;
        int b;
        int i;
        o = wr_addr[15:9];
        b = int'(wr_addr[8:6]);
        i = int'(wr_addr[5:0]);
        if (rst || !ses_en) begin
            for (int x = 0; x < NB; x++)
                for (int y = 0; y < PB; y++)
                    mdl[x][y] = 8'hFF;
            m_vld = 0;
            m_err = 0;
            m_off = '0;
        end else begin
            if (wr_en) begin
                if (!m_vld) begin
                    m_vld = 1;
                    m_off = o;
                    mdl[b][i] = wr_data;
                end else if (o == m_off) begin
                    mdl[b][i] = wr_data;
                end else begin
                    m_err = 1;
                end
            end
            if (mrg_stb)
                for (int x = 0; x < NB; x++)
                    for (int y = 0; y < PB; y++)
                        mdl[x][y] = mdl[x][y] | mrg_prog[(x*PB+y)*8 +: 8];
        end
    endtask

    task automatic compare_now();
        chk(rd_data == mdl[rd_blk][rd_idx], "R3 readback", rd_data, mdl[rd_blk][rd_idx]);
        chk(off_vld == m_vld, "R2 off_vld", off_vld, m_vld);
        if (m_vld)
            chk(page_off == m_off, "R2 page_off", page_off, m_off);
        chk(off_err == m_err, "R4 off_err", off_err, m_err);
        chk(hv_en == (blk_mask & {NB{pgm_stb}}), "R6 hv_en", hv_en, blk_mask & {NB{pgm_stb}});
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_now();
    endtask

    task automatic idle();
        wr_en   = 0;
        mrg_stb = 0;
        pgm_stb = 0;
    endtask

    // inputs idle: edges during the sweep change nothing
    task automatic sweep(input string tag);
        for (int b = 0; b < NB; b++)
            for (int i = 0; i < PB; i++) begin
                rd_blk = 3'(b);
                rd_idx = 6'(i);
                #1;
                chk(rd_data == mdl[b][i], tag, rd_data, mdl[b][i]);
            end
        @(negedge clk);
    endtask

    task automatic wr(input int o, input int b, input int i, input logic [7:0] d);
        wr_en   = 1;
        wr_addr = {7'(o), 3'(b), 6'(i)};
        wr_data = d;
        rd_blk  = 3'(b);
        rd_idx  = 6'(i);
        step();
        wr_en = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1; ses_en = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
        blk_mask = '0; pgm_stb = 0; mrg_stb = 0; mrg_prog = '0;
        rd_blk = '0; rd_idx = '0;
        @(negedge clk);
        step();
        step();
        rst = 0;
        ses_en = 1;
        step();
        // R1: reset state
        chk(off_vld == 0, "R1 off_vld", off_vld, 0);
        chk(off_err == 0, "R1 off_err", off_err, 0);
        sweep("R1 erased after reset");

        // R2 first write captures offset; R5 mask zero still stores
        blk_mask = '0;
        wr(5, 2, 3, 8'h5A);
        chk(rd_data == 8'h5A, "R5 write lands with mask 0", rd_data, 8'h5A);
        chk(page_off == 7'd5, "R2 captured offset", page_off, 5);
        blk_mask = 8'hA5;
        wr(5, 7, 63, 8'h00);
        wr(5, 0, 0, 8'h81);
        wr(5, 2, 4, 8'h3C);
        sweep("R3 only addressed bytes changed");

        // R4 mismatched offset
        wr(6, 1, 1, 8'h00);
        chk(rd_data == 8'hFF, "R4 clashing write dropped", rd_data, 8'hFF);
        chk(off_err == 1, "R4 flag raised", off_err, 1);
        wr(5, 1, 1, 8'h11);
        chk(off_err == 1, "R4 flag sticky", off_err, 1);
        chk(rd_data == 8'h11, "R3 write after clash", rd_data, 8'h11);

        // R6 high-voltage gating
        foreach (blk_mask[k]) begin
            blk_mask = NB'(1) << k;
            pgm_stb  = 1;
            #1;
            chk(hv_en == blk_mask, "R6 strobe on", hv_en, blk_mask);
            pgm_stb = 0;
            #1;
            chk(hv_en == '0, "R6 strobe off", hv_en, 0);
        end
        @(negedge clk);
        blk_mask = 8'h3C; pgm_stb = 1;
        step();
        pgm_stb = 0;

        // R8 margin update
        for (int k = 0; k < TB; k++)
            mrg_prog[k] = ((k * 13) % 7) == 3;
        mrg_stb = 1;
        step();
        idle();
        sweep("R8 margin update");

        // R9 write and margin together, same byte
        wr(5, 6, 10, 8'h00);
        mrg_prog = '0;
        mrg_prog[(6*PB+10)*8 +: 8] = 8'h0F;
        mrg_stb = 1;
        wr(5, 6, 10, 8'hA0);
        mrg_stb = 0;
        chk(rd_data == 8'hAF, "R9 write ORed with margin", rd_data, 8'hAF);

        // R7 session end dominates a write
        ses_en = 0;
        wr(5, 3, 3, 8'h00);
        chk(rd_data == 8'hFF, "R7 write with session off", rd_data, 8'hFF);
        chk(off_vld == 0, "R7 offset forgotten", off_vld, 0);
        chk(off_err == 0, "R7 error cleared", off_err, 0);
        step();
        sweep("R7 all erased");

        // R10 new session, address fields from a raw value
        ses_en = 1;
        step();
        wr_en = 1; wr_addr = 16'h1234; wr_data = 8'h77;
        rd_blk = 3'd0; rd_idx = 6'd52;
        step();
        wr_en = 0;
        chk(rd_data == 8'h77, "R10 byte 52 of block 0", rd_data, 8'h77);
        chk(page_off == 7'd9, "R10 offset field", page_off, 9);
        sweep("R10 only decoded byte changed");

        done = 1;
        summary();
        $finish;
    end

endmodule